// File: doc/BRIEF.md
# System Protection Unit: Software Watchdog and Bus Timeout Monitor

The block guards a processor subsystem against two failure modes. A software watchdog counts system clocks and, unless software proves it is alive by writing an ordered pair of key bytes, pulses a reset request when its selected period runs out. A bus monitor counts clocks while a bus cycle is open and pulses a bus error if no termination strobe arrives within the selected limit.

Software reaches the block through a one-bit-address register port. Address 0 is an 8-bit control register that can be written once after reset. Address 1 is the key (service) register. A freeze input, driven during debug halts, can pause either counter, as selected in the control register.

Control register layout (address 0): bit 7 watchdog enable, bit 6 prescaler enable, bits 5:4 watchdog period select, bits 3:2 bus limit select, bit 1 freeze pauses watchdog, bit 0 freeze pauses bus monitor. With the default parameters the watchdog period is 2^(9+2*sel) clocks, multiplied by 2^9 when the prescaler is on. The bus limit is 64 >> sel clocks.

Top module: `sys_guard`

## Requirements
- R1: After reset both outputs are low, the control register reads 0x80 (watchdog enabled, prescaler off, both selects 0, no freeze pausing), and the watchdog runs: the first reset request pulse comes 2^WD_BASE_LOG clocks after reset release.
- R2: With the prescaler off (bit 6 = 0) the watchdog period for select s (bits 5:4) is 2^(WD_BASE_LOG+WD_STEP_LOG*s) clocks (default 2^9, 2^11, 2^13, 2^15), counted from the accepting control write or the last timeout; rst_req_o is high for exactly one cycle per timeout and the count restarts.
- R3: With the prescaler on (bit 6 = 1) each period is 2^WD_PRE_LOG times longer (default 2^18, 2^20, 2^22, 2^24 clocks).
- R4: Writing 0x55 and then 0xAA to address 1 services the watchdog and reloads it to its full period, counted from the 0xAA write; writes to address 0 and reads of any address between the two keys do not break the sequence.
- R5: A 0xAA write to address 1 that does not directly follow a 0x55 write to address 1 (any other value written there in between, or no 0x55 at all) does not service; the sequence restarts at the next 0x55.
- R6: Only the first write to address 0 after reset is accepted; later writes leave the read value and behaviour unchanged. An accepted write restarts the watchdog count.
- R7: With bit 7 = 0 the watchdog is held cleared and never raises rst_req_o.
- R8: Address 1 always reads 0x00.
- R9: After a bus_start_i pulse with no bus_done_i, bus_err_o pulses for one cycle exactly 64 >> s clocks later, s being bits 3:2 (64, 32, 16, 8 with BM_MAX_LOG = 6); the cycle then closes.
- R10: bus_done_i during an open cycle closes it without an error; bus_done_i with no open cycle has no effect; bus_start_i during an open cycle (or together with bus_done_i) restarts the count.
- R11: While freeze_i is high and bit 1 is set, the watchdog count holds; with bit 1 clear, freeze_i has no effect on it.
- R12: While freeze_i is high and bit 0 is set, the bus monitor count holds and no bus error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 key |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| freeze_i | input | 1 | Debug freeze request |
| bus_start_i | input | 1 | Bus cycle start strobe |
| bus_done_i | input | 1 | Bus cycle termination strobe |
| rst_req_o | output | 1 | One-cycle watchdog reset request |
| bus_err_o | output | 1 | One-cycle bus timeout error |

## Verification
The bench targets the exact period boundaries of all eight watchdog settings and all four bus limits; an off-by-one counter would pulse a cycle early or late and the cycle count would differ. It drives a lone 0xAA, a 0x55 broken by a foreign key value, and a repeated 0x55 before 0xAA; a sequencer that remembered too much or too little would service when it must not or miss a valid service, moving the next pulse. Second writes to the control register, reads of the key register, freeze with and without its enable bits, and a restart strobe during an open bus cycle catch a register that is not locked, a leaking key value, a freeze that ignores its enable, and a monitor that keeps the old count.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic       wd_en;
    logic       pre_en;
    logic [1:0] wd_sel;
    logic [1:0] bm_sel;
    logic       frz_wd;
    logic       frz_bm;
  } guard_cfg_t;

  localparam guard_cfg_t CFG_RST = '{wd_en: 1'b1, pre_en: 1'b0, wd_sel: 2'd0,
                                     bm_sel: 2'd0, frz_wd: 1'b0, frz_bm: 1'b0};

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_KEY  = 1'b1;

  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;
endpackage

// File: rtl/guard_cfg.sv
module guard_cfg
  import guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output guard_cfg_t        cfg_o,
  output logic              lock_o,
  output logic              take_o
);
  // first write after reset wins, the rest are dropped
  assign take_o = wr_i & ~lock_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      lock_o <= 1'b0;
    end else if (take_o) begin
      cfg_o  <= guard_cfg_t'(wdata_i);
      lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/guard_key.sv
module guard_key
  import guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              fire_o
);
  logic armed_q;

  assign fire_o = wr_i & armed_q & (wdata_i == KEY_FIRE);

  // any key-register write re-evaluates the arm state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (wdata_i == KEY_ARM);
  end
endmodule

// File: rtl/guard_presc.sv
module guard_presc #(
  parameter int PRE_LOG = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pre_en_i,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (PRE_LOG == 0) begin : g_bypass
      assign tick_o = run_i;
    end else begin : g_div
      logic [PRE_LOG-1:0] div_q;

      assign tick_o = run_i & (~pre_en_i | (&div_q));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 div_q <= '0;
        else if (clr_i || !pre_en_i) div_q <= '0;
        else if (run_i)              div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/guard_wdog.sv
module guard_wdog #(
  parameter int BASE_LOG = 9,
  parameter int STEP_LOG = 2,
  parameter int PRE_LOG  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       pre_en_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,
  input  logic       clr_i,
  output logic       bite_o
);
  localparam int SEL_N = 4;
  localparam int CW    = BASE_LOG + STEP_LOG * (SEL_N - 1);

  logic          clr, run, tick;
  logic [CW-1:0] cnt_q, last;

  assign clr = ~en_i | clr_i;
  assign run = en_i & ~hold_i;

  guard_presc #(.PRE_LOG(PRE_LOG)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .pre_en_i(pre_en_i),
    .clr_i   (clr),
    .tick_o  (tick)
  );

  // terminal count = 2^(BASE+STEP*sel) - 1
  always_comb last = {CW{1'b1}} >> (STEP_LOG * (SEL_N - 1 - int'(sel_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bite_o <= 1'b0;
    end else begin
      bite_o <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == last) begin
          cnt_q  <= '0;
          bite_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/guard_bmon.sv
module guard_bmon #(
  parameter int MAX_LOG = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,
  output logic       err_o
);
  logic               busy_q;
  logic [MAX_LOG-1:0] cnt_q, last;

  always_comb last = {MAX_LOG{1'b1}} >> sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (done_i) begin
          busy_q <= 1'b0;
        end else if (!hold_i) begin
          if (cnt_q == last) begin
            busy_q <= 1'b0;
            err_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sys_guard.sv
module sys_guard
  import guard_pkg::*;
#(
  parameter int WD_BASE_LOG = 9,
  parameter int WD_STEP_LOG = 2,
  parameter int WD_PRE_LOG  = 9,
  parameter int BM_MAX_LOG  = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        freeze_i,
  input  logic        bus_start_i,
  input  logic        bus_done_i,
  output logic        rst_req_o,
  output logic        bus_err_o
);
  guard_cfg_t        cfg;
  logic [DATA_W-1:0] cfg_word;
  logic              cfg_lock, cfg_take, key_fire;
  logic              ctrl_wr, key_wr;

  assign ctrl_wr  = reg_we_i & (reg_addr_i == ADDR_CTRL);
  assign key_wr   = reg_we_i & (reg_addr_i == ADDR_KEY);
  assign cfg_word = cfg;

  // key register is write-only, reads back zero
  assign reg_rdata_o = (reg_addr_i == ADDR_CTRL) ? cfg_word : '0;

  guard_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .wdata_i(reg_wdata_i),
    .cfg_o  (cfg),
    .lock_o (cfg_lock),
    .take_o (cfg_take)
  );

  guard_key u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (key_wr),
    .wdata_i(reg_wdata_i),
    .fire_o (key_fire)
  );

  guard_wdog #(
    .BASE_LOG(WD_BASE_LOG),
    .STEP_LOG(WD_STEP_LOG),
    .PRE_LOG (WD_PRE_LOG)
  ) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg.wd_en),
    .pre_en_i(cfg.pre_en),
    .sel_i   (cfg.wd_sel),
    .hold_i  (freeze_i & cfg.frz_wd),
    .clr_i   (key_fire | cfg_take),
    .bite_o  (rst_req_o)
  );

  guard_bmon #(.MAX_LOG(BM_MAX_LOG)) u_bmon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(bus_start_i),
    .done_i (bus_done_i),
    .sel_i  (cfg.bm_sel),
    .hold_i (freeze_i & cfg.frz_bm),
    .err_o  (bus_err_o)
  );
endmodule

// File: rtl/sys_guard_chk.sv
module sys_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_addr_i,
  input logic [7:0] reg_rdata_o,
  input logic       freeze_i,
  input logic       bus_start_i,
  input logic       bus_done_i,
  input logic       rst_req_o,
  input logic       bus_err_o,
  input logic [7:0] cfg_word,
  input logic       cfg_lock
);
  // R2
  rst_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R9
  bus_err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |=> !bus_err_o);

  // R8
  key_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i |-> (reg_rdata_o == 8'h00));

  // R6
  cfg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock |=> $stable(cfg_word));

  // R7
  wd_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_word[7] |=> !rst_req_o);

  // R11
  wd_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && cfg_word[1]) |=> !rst_req_o);

  // R12
  bm_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && cfg_word[0] && !bus_start_i) |=> !bus_err_o);

  // R10
  bm_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_done_i && !bus_start_i) |=> !bus_err_o);
endmodule

bind sys_guard sys_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .freeze_i   (freeze_i),
  .bus_start_i(bus_start_i),
  .bus_done_i (bus_done_i),
  .rst_req_o  (rst_req_o),
  .bus_err_o  (bus_err_o),
  .cfg_word   (cfg_word),
  .cfg_lock   (cfg_lock)
);

// File: tb/sys_guard_test.sv
module sys_guard_test;
  localparam int BASE = 4;
  localparam int STEP = 2;
  localparam int PRE  = 3;
  localparam int BMAX = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, addr = 1'b0, freeze = 1'b0, bstart = 1'b0, bdone = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req, bus_err;

  always #10 clk = ~clk;

  sys_guard #(
    .WD_BASE_LOG(BASE), .WD_STEP_LOG(STEP), .WD_PRE_LOG(PRE), .BM_MAX_LOG(BMAX)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .freeze_i(freeze),
    .bus_start_i(bstart), .bus_done_i(bdone), .rst_req_o(rst_req), .bus_err_o(bus_err)
  );

  int    total = 0, bad = 0;
  string cur = "R1";

  function automatic int wd_len(int c);
    return 1 << (BASE + STEP * ((c >> 4) & 3) + (((c >> 6) & 1) != 0 ? PRE : 0));
  endfunction

  function automatic int bm_len(int c);
    return (1 << BMAX) >> ((c >> 2) & 3);
  endfunction

  // behavioural reference model
  int m_cfg, m_lock, m_arm, m_wc, m_busy, m_bc;
  bit m_cw, m_sv, exp_rst, exp_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 8'h80; m_lock = 0; m_arm = 0; m_wc = 0; m_busy = 0; m_bc = 0;
      exp_rst = 0; exp_err = 0;
    end else begin
      m_cw = we && !addr && m_lock == 0;
      m_sv = we && addr && wdata == 8'hAA && m_arm != 0;
      exp_rst = 0;
      exp_err = 0;
      if (m_cfg[7] == 1'b0 || m_cw || m_sv) m_wc = 0;
      else if (!(freeze && m_cfg[1])) begin
        if (m_wc == wd_len(m_cfg) - 1) begin m_wc = 0; exp_rst = 1; end
        else m_wc++;
      end
      if (bstart) begin m_busy = 1; m_bc = 0; end
      else if (m_busy != 0) begin
        if (bdone) m_busy = 0;
        else if (!(freeze && m_cfg[0])) begin
          if (m_bc == bm_len(m_cfg) - 1) begin m_busy = 0; exp_err = 1; end
          else m_bc++;
        end
      end
      if (we && addr) m_arm = (wdata == 8'h55) ? 1 : 0;
      if (m_cw) begin m_cfg = int'(wdata); m_lock = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rst_req !== exp_rst) begin
        bad++;
        $display("FAIL %s rst_req_o act=%0d exp=%0d at %0t", cur, rst_req, exp_rst, $time);
      end
      total++;
      if (bus_err !== exp_err) begin
        bad++;
        $display("FAIL %s bus_err_o act=%0d exp=%0d at %0t", cur, bus_err, exp_err, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; addr = 1'b0; wdata = 8'h00;
    freeze = 1'b0; bstart = 1'b0; bdone = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input bit a, input int d);
    we = 1'b1; addr = a; wdata = d[7:0];
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input bit a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_start();
    bstart = 1'b1; @(negedge clk); bstart = 1'b0;
  endtask

  task automatic pulse_done();
    bdone = 1'b1; @(negedge clk); bdone = 1'b0;
  endtask

  task automatic wait_pulse(input bit bus, input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if ((bus ? bus_err : rst_req) === 1'b1) begin n = i; break; end
    end
  endtask

  task automatic count_pulses(input bit bus, input int k, output int c);
    c = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if ((bus ? bus_err : rst_req) === 1'b1) c++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, d, c;

    // R1 reset state and default watchdog
    cur = "R1";
    do_reset();
    rd(1'b0, d);
    chk(d == 8'h80, "R1 ctrl reset", d, 8'h80);
    chk(rst_req === 1'b0 && bus_err === 1'b0, "R1 outputs low", int'(rst_req) + int'(bus_err), 0);
    wait_pulse(1'b0, 100, n);
    chk(n == (1 << BASE), "R1 first timeout", n, 1 << BASE);

    // R2 unprescaled periods, twice each
    cur = "R2";
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(1'b0, 8'h80 | (s << 4));
      wait_pulse(1'b0, wd_len(8'h80 | (s << 4)) + 20, n);
      chk(n == wd_len(8'h80 | (s << 4)), "R2 period", n, wd_len(8'h80 | (s << 4)));
      wait_pulse(1'b0, wd_len(8'h80 | (s << 4)) + 20, n);
      chk(n == wd_len(8'h80 | (s << 4)), "R2 repeat period", n, wd_len(8'h80 | (s << 4)));
    end

    // R3 prescaled periods
    cur = "R3";
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(1'b0, 8'hC0 | (s << 4));
      wait_pulse(1'b0, wd_len(8'hC0 | (s << 4)) + 20, n);
      chk(n == wd_len(8'hC0 | (s << 4)), "R3 prescaled period", n, wd_len(8'hC0 | (s << 4)));
    end

    // R4 service with unrelated accesses in between
    cur = "R4";
    do_reset();
    wr(1'b0, 8'h90);
    idle(40);
    wr(1'b1, 8'h55);
    rd(1'b0, d);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hAA);
    wait_pulse(1'b0, 200, n);
    chk(n == 64, "R4 reload after service", n, 64);

    // R6 control locked after first write
    cur = "R6";
    rd(1'b0, d);
    chk(d == 8'h90, "R6 ctrl kept", d, 8'h90);
    wr(1'b0, 8'h80);
    rd(1'b0, d);
    chk(d == 8'h90, "R6 second write ignored", d, 8'h90);
    wait_pulse(1'b0, 200, n);
    chk(n == 63, "R6 period unchanged", n, 63);

    // R5 broken key sequences
    cur = "R5";
    do_reset();
    wr(1'b0, 8'h90);
    idle(10);
    wr(1'b1, 8'hAA);
    wait_pulse(1'b0, 200, n);
    chk(n == 53, "R5 lone AA ignored", n, 53);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h12);
    wr(1'b1, 8'hAA);
    wait_pulse(1'b0, 200, n);
    chk(n == 61, "R5 broken pair ignored", n, 61);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    wait_pulse(1'b0, 200, n);
    chk(n == 64, "R5 restart at next 55", n, 64);

    // R8 key register reads zero
    cur = "R8";
    wr(1'b1, 8'h55);
    rd(1'b1, d);
    chk(d == 0, "R8 key reads zero", d, 0);

    // R7 watchdog disabled
    cur = "R7";
    do_reset();
    wr(1'b0, 8'h00);
    count_pulses(1'b0, 300, c);
    chk(c == 0, "R7 no request when disabled", c, 0);

    // R11 freeze pauses watchdog only when enabled
    cur = "R11";
    do_reset();
    wr(1'b0, 8'h82);
    idle(5);
    freeze = 1'b1;
    idle(100);
    freeze = 1'b0;
    wait_pulse(1'b0, 100, n);
    chk(n == 11, "R11 frozen count held", n, 11);
    do_reset();
    wr(1'b0, 8'h80);
    freeze = 1'b1;
    wait_pulse(1'b0, 100, n);
    freeze = 1'b0;
    chk(n == 16, "R11 freeze ignored without enable", n, 16);

    // R9 bus limits
    cur = "R9";
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(1'b0, s << 2);
      pulse_start();
      wait_pulse(1'b1, 100, n);
      chk(n == bm_len(s << 2), "R9 bus limit", n, bm_len(s << 2));
    end

    // R10 termination and restart
    cur = "R10";
    do_reset();
    wr(1'b0, 8'h00);
    pulse_start();
    idle(10);
    pulse_done();
    count_pulses(1'b1, 100, c);
    chk(c == 0, "R10 done closes cycle", c, 0);
    pulse_done();
    pulse_start();
    wait_pulse(1'b1, 100, n);
    chk(n == 64, "R10 idle done ignored", n, 64);
    pulse_start();
    idle(20);
    pulse_start();
    wait_pulse(1'b1, 100, n);
    chk(n == 64, "R10 start restarts count", n, 64);
    bstart = 1'b1; bdone = 1'b1;
    @(negedge clk);
    bstart = 1'b0; bdone = 1'b0;
    wait_pulse(1'b1, 100, n);
    chk(n == 64, "R10 start wins over done", n, 64);

    // R12 freeze pauses bus monitor
    cur = "R12";
    do_reset();
    wr(1'b0, 8'h01);
    pulse_start();
    idle(10);
    freeze = 1'b1;
    idle(30);
    freeze = 1'b0;
    wait_pulse(1'b1, 100, n);
    chk(n == 54, "R12 frozen bus count held", n, 54);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule